// File: doc/BRIEF.md
# Four-Bank Interleaved Line Memory

This block is the main-memory side of a cache line fill. Memory is split across four banks, and the two lowest bits of a word address choose the bank. A line request carries one line address, and that address goes to all four banks at once. The banks therefore pay their fixed access delay together, one time only. After the delay, the four words of the line leave over a one-word-wide response stream, in bank order from bank 0 to bank 3. A line write takes all four words with the request. It lands in all four banks in the same cycle, once the same access delay has run out.

Requests use a valid/ready handshake. The request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low, and `busy` stays high, from the cycle after that handshake until the operation completes. The requester may hold `req_valid` high while `req_ready` is low, and nothing is taken in those cycles. The response stream is valid/ready as well. A beat is consumed only in a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the current beat's data and last flag stay unchanged, and no later beat is presented. With `rsp_ready` held high, a read takes 1 address cycle, then LATENCY access cycles, then 4 data cycles. At the default latency this is 20 cycles. A memory that accesses one word at a time would need 65 cycles.

Top module: `ilv_linemem`

## Requirements
- R1: After reset, `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: The word at word address w is stored in bank w mod 4, at row w div 4. For a read of line L, beat k returns the word at word address 4·L+k. In `req_wline`, bits [k·DATA_W +: DATA_W] hold the word for bank k, which is word address 4·L+k.
- R3: Call the handshake cycle of a read cycle 1. With `rsp_ready` held high, the first beat is valid in cycle LATENCY+2, and the last beat is in cycle LATENCY+5. At the default latency of 15, the last beat is in cycle 20.
- R4: A read produces exactly four beats. `rsp_last` is 1 on the fourth beat only.
- R5: A line write produces no response beats. All four words are committed, and `req_ready` returns in cycle LATENCY+2, counting the handshake cycle as cycle 1. A later read of that line returns the written words.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, the next cycle still has `rsp_valid` at 1, and `rsp_data` and `rsp_last` unchanged. The beat advances only on a handshake.
- R7: From the cycle after a request handshake until the operation ends, `req_ready` is 0 and `busy` is 1. Requests presented in that window are ignored and change no stored word.
- R8: `req_ready` is 1 in the cycle after the last beat is handshaken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for a line write, 0 for a line read |
| req_line | input | LINE_W | Line address (word address divided by 4) |
| req_wline | input | BANKS*DATA_W | Write words; slice k goes to bank k |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the beat |
| rsp_data | output | DATA_W | Beat data |
| rsp_last | output | 1 | Fourth beat of the line |
| busy | output | 1 | An operation is in progress |

## Verification
The hardest state to reach from the ports is a request that arrives while the banks are still in the middle of their shared access delay. Such a request must leave no mark. The stimulus issues a line write, then holds a conflicting write to another line on the request port for several cycles before the delay expires. It then reads both lines back, to show that only the first write took effect. Back-pressure is applied as a repeating stall pattern on `rsp_ready`, so that some beats are held across several cycles, while the first-beat timing is still checked.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_BURST  = 2'd2
  } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
// One bank: synchronous single-port RAM, row addressed by the line address.
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[row] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[row];
  end
endmodule

// File: rtl/ilv_seq.sv
// Shared access counter and return sequencing for all banks.
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int DATA_W  = 32,
  parameter int LINE_W  = 6,
  parameter int LATENCY = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [BANKS*DATA_W-1:0] req_wline,
  input  logic                    rsp_ready,
  output logic [LINE_W-1:0]       bank_row,
  output logic                    bank_we,
  output logic                    bank_re,
  output logic [BANKS*DATA_W-1:0] bank_wline,
  output logic [$clog2(BANKS)-1:0] beat_sel,
  output logic                    burst_on,
  output logic                    burst_last
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam int SEL_W = $clog2(BANKS);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LATENCY - 1);
  localparam logic [SEL_W-1:0] LAST_BEAT = SEL_W'(BANKS - 1);

  ilv_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic              fire;

  assign fire       = (state == ST_ACCESS) && (cnt == '0);
  assign bank_we    = fire && is_wr;
  assign bank_re    = fire && !is_wr;
  assign req_ready  = (state == ST_IDLE);
  assign burst_on   = (state == ST_BURST);
  assign burst_last = burst_on && (beat_sel == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      is_wr      <= 1'b0;
      bank_row   <= '0;
      bank_wline <= '0;
      beat_sel   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            bank_row   <= req_line;
            bank_wline <= req_wline;
            is_wr      <= req_write;
            cnt        <= CNT_START;
            state      <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (cnt == '0) begin
            beat_sel <= '0;
            state    <= is_wr ? ST_IDLE : ST_BURST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BURST: begin
          if (rsp_ready) begin
            if (beat_sel == LAST_BEAT) state <= ST_IDLE;
            else                       beat_sel <= beat_sel + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_beat_sel.sv
// Chooses the bank output for the current beat.
module ilv_beat_sel #(
  parameter int BANKS  = 4,
  parameter int DATA_W = 32
) (
  input  logic [BANKS-1:0][DATA_W-1:0] words,
  input  logic [$clog2(BANKS)-1:0]     sel,
  output logic [DATA_W-1:0]            data
);
  always_comb data = words[sel];
endmodule

// File: rtl/ilv_linemem.sv
module ilv_linemem #(
  parameter int BANKS   = 4,
  parameter int DATA_W  = 32,
  parameter int LINE_W  = 6,
  parameter int LATENCY = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [BANKS*DATA_W-1:0] req_wline,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_last,
  output logic                    busy
);
  localparam int SEL_W = $clog2(BANKS);

  logic [LINE_W-1:0]            row;
  logic                         we, re;
  logic [BANKS*DATA_W-1:0]      wline;
  logic [SEL_W-1:0]             beat;
  logic [BANKS-1:0][DATA_W-1:0] bank_q;

  ilv_seq #(
    .BANKS(BANKS), .DATA_W(DATA_W), .LINE_W(LINE_W), .LATENCY(LATENCY)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_wline(req_wline),
    .rsp_ready(rsp_ready),
    .bank_row(row), .bank_we(we), .bank_re(re), .bank_wline(wline),
    .beat_sel(beat), .burst_on(rsp_valid), .burst_last(rsp_last)
  );

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    ilv_bank #(.DATA_W(DATA_W), .ROW_W(LINE_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .row(row), .we(we), .re(re),
      .wdata(wline[k*DATA_W +: DATA_W]),
      .rdata(bank_q[k])
    );
  end

  ilv_beat_sel #(.BANKS(BANKS), .DATA_W(DATA_W)) u_sel (
    .words(bank_q), .sel(beat), .data(rsp_data)
  );

  assign busy = !req_ready;
endmodule

// File: rtl/ilv_linemem_chk.sv
module ilv_linemem_chk #(
  parameter int BANKS   = 4,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_last,
  input logic              busy
);
  logic        acc;
  logic [15:0] lat_cnt;
  logic [7:0]  beats;
  logic        wr_flag;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      beats   <= '0;
      wr_flag <= 1'b0;
    end else begin
      if (acc)                        lat_cnt <= '0;
      else if (lat_cnt != 16'hFFFF)   lat_cnt <= lat_cnt + 1'b1;
      if (acc)                        beats <= '0;
      else if (rsp_valid && rsp_ready) beats <= beats + 1'b1;
      if (acc)                        wr_flag <= req_write;
    end
  end

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat_cnt == 16'(LATENCY)));

  assert_four_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> (beats == 8'(BANKS - 1)));

  assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !wr_flag);

  assert_hold_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  assert_refuse_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!req_ready && busy));

  assert_beat_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_last) |=> req_ready);
endmodule

bind ilv_linemem ilv_linemem_chk #(
  .BANKS(BANKS), .DATA_W(DATA_W), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_last(rsp_last), .busy(busy)
);

// File: tb/tb_ilv_linemem.sv
module tb_ilv_linemem;
  localparam int LAT = 15;
  localparam int DW  = 32;
  localparam int LW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [4*DW-1:0] req_wline = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_last;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [4 << LW];

  always #5 clk = ~clk;

  ilv_linemem #(.BANKS(4), .DATA_W(DW), .LINE_W(LW), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_wline(req_wline),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int w);
    return DW'(32'h9E3779B1 * (seed + 1)) ^ DW'(w * 32'h01010101) ^ DW'(w);
  endfunction

  // R5: line write, commit timing and silence on the response side
  task automatic do_write(input int line, input int seed);
    int n;
    bit saw_beat;
    @(negedge clk);
    chk(req_ready, "R7 ready before write", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b1; req_line = LW'(line);
    for (int k = 0; k < 4; k++) begin
      req_wline[k*DW +: DW] = pat(seed, line*4 + k);
      ref_mem[line*4 + k]   = pat(seed, line*4 + k);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    n = 2; saw_beat = 1'b0;
    while (!req_ready && n < 200) begin
      if (!busy) saw_beat = 1'b1;
      if (rsp_valid) saw_beat = 1'b1;
      @(negedge clk); n++;
    end
    chk(n == LAT + 2, "R5 write ready cycle", 32'(n), 32'(LAT + 2));
    chk(!saw_beat, "R5 no beat and busy held during write", 32'(saw_beat), 0);
  endtask

  // R2 R3 R4 R6 R8: line read, optional stall pattern on rsp_ready
  task automatic do_read(input int line, input bit stall);
    int n, beat, first_n, last_n;
    bit done;
    @(negedge clk);
    chk(req_ready, "R7 ready before read", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b0; req_line = LW'(line);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 2; beat = 0; done = 1'b0; first_n = 0; last_n = 0;
    while (!done && n < 400) begin
      rsp_ready = stall ? ((n % 3) != 0) : 1'b1;
      if (rsp_valid) begin
        if (first_n == 0) first_n = n;
        chk(rsp_data == ref_mem[line*4 + beat], "R2 beat data", rsp_data, ref_mem[line*4 + beat]);
        chk(rsp_last == (beat == 3), "R4 last flag", 32'(rsp_last), 32'(beat == 3));
        chk(busy && !req_ready, "R7 busy during beat", 32'(req_ready), 0);
        if (rsp_ready) begin
          if (rsp_last || beat == 3) begin done = 1'b1; last_n = n; end
          beat++;
        end
      end
      if (!done) begin @(negedge clk); n++; end
    end
    chk(first_n == LAT + 2, "R3 first beat cycle", 32'(first_n), 32'(LAT + 2));
    if (!stall) chk(last_n == LAT + 5, "R3 last beat cycle", 32'(last_n), 32'(LAT + 5));
    chk(beat == 4, "R4 beat count", 32'(beat), 4);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R8 ready after last beat", 32'({req_ready, rsp_valid}), 32'h2);
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
  endtask

  // R7: a conflicting write held during the access delay must be ignored
  task automatic test_ignored();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_line = LW'(9);
    for (int k = 0; k < 4; k++) begin
      req_wline[k*DW +: DW] = pat(77, 36 + k);
      ref_mem[36 + k]       = pat(77, 36 + k);
    end
    @(posedge clk);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_line = LW'(12);
      req_wline = {4{32'hDEAD_0000 | 32'(c)}};
      chk(!req_ready, "R7 refused while busy", 32'(req_ready), 0);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    while (!req_ready) @(negedge clk);
    do_read(12, 1'b0);
    do_read(9, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    do_write(0, 1);
    do_write(1, 2);
    do_write(12, 3);
    do_write(63, 4);
    do_read(0, 1'b0);
    do_read(1, 1'b0);
    do_read(63, 1'b0);
    do_read(12, 1'b1);
    do_read(63, 1'b1);
    test_ignored();
    do_write(1, 5);
    do_read(1, 1'b0);
    do_read(0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule